// File: doc/BRIEF.md
# Segment register load controller

This block performs the protection checks for loading a segment register of a processor core. A caller hands it one load request per cycle: a 16-bit selector, a target register code, the current privilege level, the protected-mode and virtual-8086 flags, and the descriptor that a separate table walker has already fetched and decoded. The caller also supplies two lookup status bits: one says the selector is null, the other says the lookup failed for another reason.

The targets are the four data segment registers, the stack segment register and the local table register. For each request the block either commits the visible selector and a hidden descriptor cache entry, or raises a fault with a vector and a 16-bit error code. It also flags requests that this path may not serve. Outside protected mode, and in virtual-8086 mode, no descriptor is consulted. The block forms the cache entry itself from the selector.

The outcome appears one clock after the request. Every stored selector and cache entry can be read back combinationally through an index port.

Top module: `seg_load_ctrl`

## Requirements
- R1: After reset every stored selector is 0, every cache entry is all zero (valid 0), the stack-size flag `ss_big_o` is 0, and `done_o`, `fault_o` and `illegal_o` are low.
- R2: A request with `req_i` high at a rising edge produces exactly one of `done_o`, `fault_o` or `illegal_o`, high for the single cycle after that edge. With no request, all three stay low.
- R3: When `prot_i` is 0 or `v86_i` is 1, a load into ES, SS, DS, FS or GS stores the selector. The cache becomes: valid 1, present 1, system 0, type 4'b0010 (writable data), base = selector << 4, limit 0xFFFF, D 0, and DPL 3 when `v86_i` is 1, else 0. A load into SS this way also clears `ss_big_o`.
- R4: Target code 1 (code segment), code 7, and target 6 (local table) outside protected mode raise `illegal_o` and change no state. Target codes are: 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS, 6 local table.
- R5: In protected mode, a null selector (`lk_null_i`) loaded into ES, DS, FS or GS is accepted. The selector is stored and the cache is cleared to all zero.
- R6: In protected mode, a null selector or a lookup failure (`lk_err_i`) into SS, or a lookup failure into a data register, faults with vector 13. The error code is the selector with bits [1:0] cleared.
- R7: An SS load faults with vector 13 unless all of these hold: RPL (selector[1:0]) equals CPL, DPL equals CPL, system flag 0, type[3] 0 (data) and type[2:1]... specifically type[1] 1 (writable).
- R8: An SS load that passes R7 but whose descriptor is not present faults with vector 12, error code as in R6.
- R9: A data register load faults with vector 13 on a system descriptor or on a code descriptor with type[1] 0 (execute-only). For data, or for code with type[2] 0 (non-conforming), it also faults when RPL > DPL or CPL > DPL.
- R10: A data register load that passes R9 but whose descriptor is not present faults with vector 11, error code as in R6.
- R11: A successful protected SS load stores the selector with bits [1:0] replaced by CPL and sets `ss_big_o` to the descriptor D bit.
- R12: A local table load with a null selector sets the stored selector and the cache to zero. A lookup failure, a selector with bit 2 set, or a descriptor that is not a system descriptor of type 2 faults with vector 13. A non-present one faults with vector 11. Both use the full selector as error code.
- R13: A fault or illegal request leaves every stored selector, every cache entry and `ss_big_o` unchanged.
- R14: A successful protected load of a present descriptor stores valid 1 together with the supplied present, system, type, DPL, D, base and limit fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Load request |
| tgt_i | input | 3 | Target register code |
| sel_i | input | 16 | Selector to load |
| cpl_i | input | 2 | Current privilege level |
| prot_i | input | 1 | Protected mode enabled |
| v86_i | input | 1 | Virtual-8086 mode |
| lk_null_i | input | 1 | Lookup reports a null selector |
| lk_err_i | input | 1 | Lookup failed (other than null) |
| d_sys_i | input | 1 | Descriptor is a system descriptor |
| d_type_i | input | 4 | Descriptor type field |
| d_dpl_i | input | 2 | Descriptor privilege level |
| d_present_i | input | 1 | Descriptor present |
| d_big_i | input | 1 | Descriptor D bit |
| d_base_i | input | 32 | Descriptor base |
| d_limit_i | input | 32 | Descriptor limit |
| done_o | output | 1 | Load committed |
| fault_o | output | 1 | Load faulted |
| illegal_o | output | 1 | Request not served by this path |
| fault_vec_o | output | 8 | Fault vector |
| fault_err_o | output | 16 | Fault error code |
| ss_big_o | output | 1 | Stack-size flag |
| rd_idx_i | input | 3 | Readback target code |
| rd_sel_o | output | 16 | Readback selector |
| rd_valid_o | output | 1 | Readback cache valid |
| rd_present_o | output | 1 | Readback cache present |
| rd_sys_o | output | 1 | Readback cache system flag |
| rd_type_o | output | 4 | Readback cache type |
| rd_dpl_o | output | 2 | Readback cache DPL |
| rd_big_o | output | 1 | Readback cache D bit |
| rd_base_o | output | 32 | Readback cache base |
| rd_limit_o | output | 32 | Readback cache limit |

## Verification
A single request often breaks more than one rule at once. Examples are a privilege mismatch on a stack load whose descriptor is also not present, or a lookup failure on a selector whose supplied descriptor is also system-typed. Random stimulus draws every descriptor field independently, so these overlaps occur often. Directed cases stack a not-present descriptor on top of a privilege violation. The bench judges each overlap by the vector it sees: the rule order in the requirements decides which fault wins, and the stored state must stay unchanged whichever fault it is.

// File: rtl/seg_load_pkg.sv
package seg_load_pkg;
  parameter int unsigned SEL_W = 16;
  parameter int unsigned ADR_W = 32;
  parameter int unsigned TGT_W = 3;
  parameter int unsigned VEC_W = 8;
  localparam int unsigned NUM_SLOTS = 1 << TGT_W;

  typedef enum logic [TGT_W-1:0] {
    T_ES = 3'd0, T_CS = 3'd1, T_SS = 3'd2, T_DS = 3'd3,
    T_FS = 3'd4, T_GS = 3'd5, T_LDT = 3'd6, T_RSV = 3'd7
  } tgt_e;

  typedef enum logic [1:0] {ACT_NONE, ACT_COMMIT, ACT_FAULT, ACT_ILLEGAL} act_e;

  localparam logic [VEC_W-1:0] VEC_GP = VEC_W'(13);
  localparam logic [VEC_W-1:0] VEC_SS = VEC_W'(12);
  localparam logic [VEC_W-1:0] VEC_NP = VEC_W'(11);
  localparam logic [3:0]       LDT_TYPE = 4'd2;

  typedef struct packed {
    logic             valid;
    logic             present;
    logic             sys;
    logic [3:0]       typ;
    logic [1:0]       dpl;
    logic             big;
    logic [ADR_W-1:0] base;
    logic [ADR_W-1:0] limit;
  } seg_cache_t;

  typedef struct packed {
    act_e             act;
    logic [SEL_W-1:0] sel;
    seg_cache_t       cache;
    logic             set_big;
    logic             big;
    logic [VEC_W-1:0] vec;
    logic [SEL_W-1:0] err;
  } decision_t;
endpackage

// File: rtl/seg_default_desc.sv
module seg_default_desc
  import seg_load_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  input  logic             v86_i,
  output seg_cache_t       dflt_o
);
  localparam int unsigned PARA_SH = 4;
  localparam logic [ADR_W-1:0] REAL_LIMIT = ADR_W'(32'h0000_FFFF);

  always_comb begin
    dflt_o         = '0;
    dflt_o.valid   = 1'b1;
    dflt_o.present = 1'b1;
    dflt_o.sys     = 1'b0;
    dflt_o.typ     = 4'b0010;
    dflt_o.dpl     = v86_i ? 2'd3 : 2'd0;
    dflt_o.big     = 1'b0;
    dflt_o.base    = ADR_W'(sel_i) << PARA_SH;
    dflt_o.limit   = REAL_LIMIT;
  end
endmodule

// File: rtl/seg_rule_check.sv
module seg_rule_check
  import seg_load_pkg::*;
(
  input  logic             req_i,
  input  tgt_e             tgt_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [1:0]       cpl_i,
  input  logic             prot_i,
  input  logic             v86_i,
  input  logic             lk_null_i,
  input  logic             lk_err_i,
  input  seg_cache_t       desc_i,
  input  seg_cache_t       dflt_i,
  output decision_t        dec_o
);
  logic             legacy;
  logic [1:0]       rpl;
  logic             is_code, conforming, rw_bit;
  logic [SEL_W-1:0] idx_err;

  assign legacy     = !prot_i || v86_i;
  assign rpl        = sel_i[1:0];
  assign is_code    = desc_i.typ[3];
  assign conforming = desc_i.typ[2];
  assign rw_bit     = desc_i.typ[1];
  assign idx_err    = {sel_i[SEL_W-1:2], 2'b00};

  always_comb begin
    dec_o         = '0;
    dec_o.act     = ACT_NONE;
    dec_o.sel     = sel_i;
    dec_o.cache   = desc_i;
    dec_o.vec     = VEC_GP;
    dec_o.err     = idx_err;
    if (req_i) begin
      dec_o.act = ACT_COMMIT;
      if (tgt_i == T_CS || tgt_i == T_RSV || (tgt_i == T_LDT && legacy)) begin
        dec_o.act = ACT_ILLEGAL;
      end else if (legacy) begin
        dec_o.cache   = dflt_i;
        dec_o.set_big = (tgt_i == T_SS);
        dec_o.big     = 1'b0;
      end else if (tgt_i == T_SS) begin
        if (lk_null_i || lk_err_i) begin
          dec_o.act = ACT_FAULT;
        end else if (rpl != cpl_i || desc_i.dpl != cpl_i || desc_i.sys || is_code || !rw_bit) begin
          dec_o.act = ACT_FAULT;
        end else if (!desc_i.present) begin
          dec_o.act = ACT_FAULT;
          dec_o.vec = VEC_SS;
        end else begin
          dec_o.sel     = {sel_i[SEL_W-1:2], cpl_i};
          dec_o.set_big = 1'b1;
          dec_o.big     = desc_i.big;
        end
      end else if (tgt_i == T_LDT) begin
        dec_o.err = sel_i;
        if (lk_null_i) begin
          dec_o.sel   = '0;
          dec_o.cache = '0;
        end else if (lk_err_i || sel_i[2]) begin
          dec_o.act = ACT_FAULT;
        end else if (!desc_i.sys || desc_i.typ != LDT_TYPE) begin
          dec_o.act = ACT_FAULT;
        end else if (!desc_i.present) begin
          dec_o.act = ACT_FAULT;
          dec_o.vec = VEC_NP;
        end
      end else begin
        if (lk_null_i) begin
          dec_o.cache = '0;
        end else if (lk_err_i) begin
          dec_o.act = ACT_FAULT;
        end else if (desc_i.sys || (is_code && !rw_bit)) begin
          dec_o.act = ACT_FAULT;
        end else if ((!is_code || !conforming) && (rpl > desc_i.dpl || cpl_i > desc_i.dpl)) begin
          dec_o.act = ACT_FAULT;
        end else if (!desc_i.present) begin
          dec_o.act = ACT_FAULT;
          dec_o.vec = VEC_NP;
        end
      end
    end
  end
endmodule

// File: rtl/seg_reg_file.sv
module seg_reg_file
  import seg_load_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] wr_en_i,
  input  logic [SEL_W-1:0]     wr_sel_i,
  input  seg_cache_t           wr_cache_i,
  input  logic [TGT_W-1:0]     rd_idx_i,
  output logic [SEL_W-1:0]     rd_sel_o,
  output seg_cache_t           rd_cache_o
);
  logic [SEL_W-1:0] sel_q   [NUM_SLOTS];
  seg_cache_t       cache_q [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sel_q[s]   <= '0;
        cache_q[s] <= '0;
      end else if (wr_en_i[s]) begin
        sel_q[s]   <= wr_sel_i;
        cache_q[s] <= wr_cache_i;
      end
    end
  end

  assign rd_sel_o   = sel_q[rd_idx_i];
  assign rd_cache_o = cache_q[rd_idx_i];
endmodule

// File: rtl/seg_load_ctrl.sv
module seg_load_ctrl
  import seg_load_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        tgt_i,
  input  logic [15:0]       sel_i,
  input  logic [1:0]        cpl_i,
  input  logic              prot_i,
  input  logic              v86_i,
  input  logic              lk_null_i,
  input  logic              lk_err_i,
  input  logic              d_sys_i,
  input  logic [3:0]        d_type_i,
  input  logic [1:0]        d_dpl_i,
  input  logic              d_present_i,
  input  logic              d_big_i,
  input  logic [31:0]       d_base_i,
  input  logic [31:0]       d_limit_i,
  output logic              done_o,
  output logic              fault_o,
  output logic              illegal_o,
  output logic [7:0]        fault_vec_o,
  output logic [15:0]       fault_err_o,
  output logic              ss_big_o,
  input  logic [2:0]        rd_idx_i,
  output logic [15:0]       rd_sel_o,
  output logic              rd_valid_o,
  output logic              rd_present_o,
  output logic              rd_sys_o,
  output logic [3:0]        rd_type_o,
  output logic [1:0]        rd_dpl_o,
  output logic              rd_big_o,
  output logic [31:0]       rd_base_o,
  output logic [31:0]       rd_limit_o
);
  seg_cache_t           desc_in, dflt, rd_cache;
  decision_t            dec;
  logic [NUM_SLOTS-1:0] wr_en;

  always_comb begin
    desc_in         = '0;
    desc_in.valid   = 1'b1;
    desc_in.present = d_present_i;
    desc_in.sys     = d_sys_i;
    desc_in.typ     = d_type_i;
    desc_in.dpl     = d_dpl_i;
    desc_in.big     = d_big_i;
    desc_in.base    = d_base_i;
    desc_in.limit   = d_limit_i;
  end

  seg_default_desc u_dflt (
    .sel_i  (sel_i),
    .v86_i  (v86_i),
    .dflt_o (dflt)
  );

  seg_rule_check u_rules (
    .req_i     (req_i),
    .tgt_i     (tgt_e'(tgt_i)),
    .sel_i     (sel_i),
    .cpl_i     (cpl_i),
    .prot_i    (prot_i),
    .v86_i     (v86_i),
    .lk_null_i (lk_null_i),
    .lk_err_i  (lk_err_i),
    .desc_i    (desc_in),
    .dflt_i    (dflt),
    .dec_o     (dec)
  );

  always_comb begin
    wr_en = '0;
    if (dec.act == ACT_COMMIT) wr_en[tgt_i] = 1'b1;
  end

  seg_reg_file u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_sel_i   (dec.sel),
    .wr_cache_i (dec.cache),
    .rd_idx_i   (rd_idx_i),
    .rd_sel_o   (rd_sel_o),
    .rd_cache_o (rd_cache)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      fault_o     <= 1'b0;
      illegal_o   <= 1'b0;
      fault_vec_o <= '0;
      fault_err_o <= '0;
      ss_big_o    <= 1'b0;
    end else begin
      done_o    <= (dec.act == ACT_COMMIT);
      fault_o   <= (dec.act == ACT_FAULT);
      illegal_o <= (dec.act == ACT_ILLEGAL);
      if (dec.act == ACT_FAULT) begin
        fault_vec_o <= dec.vec;
        fault_err_o <= dec.err;
      end
      if (dec.act == ACT_COMMIT && dec.set_big) ss_big_o <= dec.big;
    end
  end

  assign rd_valid_o   = rd_cache.valid;
  assign rd_present_o = rd_cache.present;
  assign rd_sys_o     = rd_cache.sys;
  assign rd_type_o    = rd_cache.typ;
  assign rd_dpl_o     = rd_cache.dpl;
  assign rd_big_o     = rd_cache.big;
  assign rd_base_o    = rd_cache.base;
  assign rd_limit_o   = rd_cache.limit;
endmodule

// File: rtl/seg_load_chk.sv
module seg_load_chk
  import seg_load_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic [2:0]           tgt_i,
  input logic                 done_o,
  input logic                 fault_o,
  input logic                 illegal_o,
  input logic [7:0]           fault_vec_o,
  input logic                 ss_big_o,
  input logic [NUM_SLOTS-1:0] wr_en
);
  p_single_outcome_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, fault_o, illegal_o}));

  p_req_answered_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (done_o || fault_o || illegal_o));

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !(done_o || fault_o || illegal_o));

  p_vec_legal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (fault_vec_o == VEC_GP || fault_vec_o == VEC_SS || fault_vec_o == VEC_NP));

  p_fault_no_write_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> ($past(wr_en) == '0 && $stable(ss_big_o)));

  p_illegal_no_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> ($past(wr_en) == '0 && $stable(ss_big_o)));

  p_stack_vec_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && fault_vec_o == VEC_SS) |-> ($past(tgt_i) == T_SS));
endmodule

bind seg_load_ctrl seg_load_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .tgt_i       (tgt_i),
  .done_o      (done_o),
  .fault_o     (fault_o),
  .illegal_o   (illegal_o),
  .fault_vec_o (fault_vec_o),
  .ss_big_o    (ss_big_o),
  .wr_en       (wr_en)
);

// File: tb/seg_load_ctrl_test.sv
`timescale 1ns/1ps
module seg_load_ctrl_test;
  import seg_load_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req = 0, prot = 0, v86 = 0, lk_null = 0, lk_err = 0;
  logic [2:0]  tgt = 0, rd_idx = 0;
  logic [15:0] sel = 0;
  logic [1:0]  cpl = 0, dpl = 0;
  logic        dsys = 0, dpres = 0, dbig = 0;
  logic [3:0]  dtyp = 0;
  logic [31:0] dbase = 0, dlim = 0;

  logic        done, fault, illegal, ss_big;
  logic [7:0]  fvec;
  logic [15:0] ferr, rsel;
  logic        rvalid, rpres, rsys, rbig;
  logic [3:0]  rtyp;
  logic [1:0]  rdpl;
  logic [31:0] rbase, rlim;

  seg_load_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .tgt_i(tgt), .sel_i(sel), .cpl_i(cpl),
    .prot_i(prot), .v86_i(v86), .lk_null_i(lk_null), .lk_err_i(lk_err),
    .d_sys_i(dsys), .d_type_i(dtyp), .d_dpl_i(dpl), .d_present_i(dpres), .d_big_i(dbig),
    .d_base_i(dbase), .d_limit_i(dlim),
    .done_o(done), .fault_o(fault), .illegal_o(illegal), .fault_vec_o(fvec),
    .fault_err_o(ferr), .ss_big_o(ss_big), .rd_idx_i(rd_idx), .rd_sel_o(rsel),
    .rd_valid_o(rvalid), .rd_present_o(rpres), .rd_sys_o(rsys), .rd_type_o(rtyp),
    .rd_dpl_o(rdpl), .rd_big_o(rbig), .rd_base_o(rbase), .rd_limit_o(rlim)
  );

  int n_chk = 0, n_bad = 0;
  logic [15:0] exp_sel   [8];
  seg_cache_t  exp_cache [8];
  logic        exp_big;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // outcome: 1 commit, 2 fault, 3 illegal
  task automatic model(output int act, output logic [7:0] vec, output logic [15:0] err,
                       output string tag);
    bit legacy = !prot || v86;
    bit code = dtyp[3], conf = dtyp[2], rw = dtyp[1];
    logic [1:0] rpl = sel[1:0];
    seg_cache_t c;
    c = '0; c.valid = 1; c.present = dpres; c.sys = dsys; c.typ = dtyp; c.dpl = dpl;
    c.big = dbig; c.base = dbase; c.limit = dlim;
    act = 1; vec = 8'd13; err = {sel[15:2], 2'b00}; tag = "R14";
    if (tgt == 1 || tgt == 7 || (tgt == 6 && legacy)) begin
      act = 3; tag = "R4";
    end else if (legacy) begin
      tag = "R3";
      exp_sel[tgt] = sel;
      exp_cache[tgt] = '0;
      exp_cache[tgt].valid = 1; exp_cache[tgt].present = 1; exp_cache[tgt].typ = 4'b0010;
      exp_cache[tgt].dpl = v86 ? 2'd3 : 2'd0;
      exp_cache[tgt].base = {12'h0, sel, 4'h0};
      exp_cache[tgt].limit = 32'h0000_FFFF;
      if (tgt == 2) exp_big = 0;
    end else if (tgt == 2) begin
      if (lk_null || lk_err) begin act = 2; tag = "R6"; end
      else if (rpl != cpl || dpl != cpl || dsys || code || !rw) begin act = 2; tag = "R7"; end
      else if (!dpres) begin act = 2; vec = 8'd12; tag = "R8"; end
      else begin
        tag = "R11"; exp_sel[2] = {sel[15:2], cpl}; exp_cache[2] = c; exp_big = dbig;
      end
    end else if (tgt == 6) begin
      err = sel; tag = "R12";
      if (lk_null) begin exp_sel[6] = 0; exp_cache[6] = '0; end
      else if (lk_err || sel[2]) act = 2;
      else if (!dsys || dtyp != 4'd2) act = 2;
      else if (!dpres) begin act = 2; vec = 8'd11; end
      else begin exp_sel[6] = sel; exp_cache[6] = c; end
    end else begin
      if (lk_null) begin tag = "R5"; exp_sel[tgt] = sel; exp_cache[tgt] = '0; end
      else if (lk_err) begin act = 2; tag = "R6"; end
      else if (dsys || (code && !rw)) begin act = 2; tag = "R9"; end
      else if ((!code || !conf) && (rpl > dpl || cpl > dpl)) begin act = 2; tag = "R9"; end
      else if (!dpres) begin act = 2; vec = 8'd11; tag = "R10"; end
      else begin exp_sel[tgt] = sel; exp_cache[tgt] = c; end
    end
  endtask

  task automatic check_state(input string tag);
    seg_cache_t got;
    for (int s = 0; s < 8; s++) begin
      rd_idx = 3'(s);
      #0.1;
      got = '0;
      got.valid = rvalid; got.present = rpres; got.sys = rsys; got.typ = rtyp;
      got.dpl = rdpl; got.big = rbig; got.base = rbase; got.limit = rlim;
      chk(rsel == exp_sel[s] && got == exp_cache[s], tag, $sformatf("slot %0d sel/cache", s),
          {got, rsel}, {exp_cache[s], exp_sel[s]});
    end
    chk(ss_big == exp_big, tag, "ss_big", ss_big, exp_big);
  endtask

  task automatic do_op();
    int act; logic [7:0] vec; logic [15:0] err; string tag;
    @(negedge clk);
    req = 1;
    model(act, vec, err, tag);
    @(negedge clk);
    req = 0;
    chk({done, fault, illegal} == {act == 1, act == 2, act == 3}, "R2", "outcome",
        {done, fault, illegal}, {act == 1, act == 2, act == 3});
    if (act == 2) begin
      chk(fvec == vec, tag, "vector", fvec, vec);
      chk(ferr == err, tag, "error code", ferr, err);
    end
    check_state((act == 1) ? tag : "R13");
    @(negedge clk);
    chk(!(done || fault || illegal), "R2", "idle after pulse", {done, fault, illegal}, 0);
  endtask

  task automatic good_data(input logic [1:0] p);
    lk_null = 0; lk_err = 0; dsys = 0; dtyp = 4'b0010; dpl = p; dpres = 1; dbig = 0;
    dbase = 32'h0040_0000; dlim = 32'h000F_FFFF;
  endtask

  always begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    for (int s = 0; s < 8; s++) begin exp_sel[s] = 0; exp_cache[s] = '0; end
    exp_big = 0;
    #9 rst_n = 1;
    @(negedge clk);
    chk(!(done || fault || illegal), "R1", "outputs after reset", {done, fault, illegal}, 0);
    check_state("R1");

    // R3 real mode DS, v86 SS
    prot = 0; v86 = 0; tgt = 3; sel = 16'h1234; do_op();
    prot = 1; v86 = 1; tgt = 2; sel = 16'hBEEF; do_op();
    // R4 code segment and reserved code
    prot = 1; v86 = 0; tgt = 1; sel = 16'h0008; good_data(0); do_op();
    tgt = 7; do_op();
    prot = 0; tgt = 6; do_op();
    // R11 stack commit with D=1
    prot = 1; cpl = 2; tgt = 2; sel = 16'h0032; good_data(2); dbig = 1; do_op();
    // R8 stack not present plus privilege mismatch (R7 wins), then pure not present
    sel = 16'h0031; dpres = 0; do_op();
    sel = 16'h0032; do_op();
    // R6 null into stack, R5 null into data
    lk_null = 1; sel = 16'h0003; do_op();
    tgt = 4; do_op();
    // R9 execute-only code, conforming readable code below CPL accepted
    good_data(0); tgt = 5; cpl = 3; sel = 16'h0043; dtyp = 4'b1000; do_op();
    dtyp = 4'b1110; do_op();
    dtyp = 4'b1010; do_op();
    // R10 data not present
    good_data(3); tgt = 0; sel = 16'h0053; dpres = 0; do_op();
    // R12 local table: null, TI set, wrong type, good
    tgt = 6; lk_null = 1; sel = 16'h0000; do_op();
    good_data(0); dsys = 1; sel = 16'h0064; dtyp = 4'd2; do_op();
    sel = 16'h0060; dtyp = 4'd9; do_op();
    dtyp = 4'd2; dpres = 0; do_op();
    dpres = 1; do_op();

    for (int i = 0; i < 400; i++) begin
      tgt = 3'($urandom_range(0, 7));
      prot = ($urandom_range(0, 3) != 0); v86 = ($urandom_range(0, 3) == 0);
      sel = 16'($urandom); cpl = 2'($urandom);
      lk_null = ($urandom_range(0, 9) == 0); lk_err = ($urandom_range(0, 9) == 0);
      dsys = ($urandom_range(0, 3) == 0); dtyp = 4'($urandom); dpl = 2'($urandom);
      dpres = ($urandom_range(0, 6) != 0); dbig = 1'($urandom);
      dbase = $urandom; dlim = $urandom;
      if ($urandom_range(0, 9) < 4) begin
        sel[1:0] = cpl; dpl = cpl; dsys = 0; dtyp[3] = 0; dtyp[1] = 1;
      end
      if (tgt == 6 && $urandom_range(0, 1) == 1) begin sel[2] = 0; dsys = 1; dtyp = 4'd2; end
      do_op();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule